// File: doc/BRIEF.md
# Compressed-Aware Instruction Fetch Unit

The block fetches one instruction at the current program counter for a core that mixes 16-bit compressed and 32-bit base encodings. A fetch starts with a single-cycle `start` pulse. The unit first checks the alignment of the program counter. It then works in halfword steps. Each step asks an external translator for the physical address of one halfword and then reads that halfword from an external memory port. Both are request/response interfaces. A request is held until its response-valid is seen.

The unit stops after the low halfword when that halfword is a complete compressed instruction. Otherwise it translates and reads the halfword two bytes above. Because the two halves are handled separately, a fault on the upper half is reported at PC+2, the precise address of the halfword that failed. The result is a tagged record: a full 32-bit word, a compressed halfword, or an error carrying an exception code and a faulting address. The record is presented for one cycle together with `done`.

The state machine has six states:

| State | What happens |
|---|---|
| IDLE | Waits for `start`. |
| XLATE_LO | Translates PC. |
| READ_LO | Reads the low halfword. |
| XLATE_HI | Translates PC+2. |
| READ_HI | Reads the upper halfword. |
| DONE | Raises `done` for one cycle. |

The transitions are:

- IDLE→DONE when `start` arrives with a misaligned PC.
- IDLE→XLATE_LO when `start` arrives with an aligned PC.
- XLATE_LO→DONE on a translation fault.
- XLATE_LO→READ_LO on a successful translation.
- READ_LO→DONE on a read fault, or on a compressed halfword.
- READ_LO→XLATE_HI on a halfword that marks a 32-bit instruction.
- XLATE_HI→DONE on a translation fault.
- XLATE_HI→READ_HI on a successful translation.
- READ_HI→DONE on any response.
- DONE→IDLE always.

Top module: `ifetch_unit`

## Requirements
- R1: If PC bit 0 is 1, the fetch ends with tag 2'b10, exception code 0 (misaligned) and address PC. `done` comes in the cycle after `start` is sampled, and no translation or memory request is issued.
- R2: If PC bit 1 is 1 while `half_en` is 0, the fetch ends with the misaligned error of R1. If PC bit 1 is 1 while `half_en` is 1, the fetch proceeds normally.
- R3: Every memory read is preceded by its own translation. The first translation uses PC and the second uses PC+2, wrapping at the address width. Each read uses the physical address that its own translation returned.
- R4: A low halfword whose bits 1:0 are not 2'b11 gives tag 2'b01 and `res_insn` = {16'h0000, halfword}. No second translation or read is made.
- R5: A low halfword whose bits 1:0 equal 2'b11 leads to a second access. On success the result has tag 2'b00, with the upper halfword in `res_insn[31:16]` and the lower halfword in `res_insn[15:0]`.
- R6: A translation fault gives tag 2'b10 and passes the translator's code through unchanged. The reported address is PC for the first half and PC+2 for the second half.
- R7: A memory read fault gives tag 2'b10 with exception code 1 (access fault). The reported address is PC for the low half and PC+2 for the upper half.
- R8: `busy` is 1 from the cycle after `start` until `done`, and `done` lasts exactly one cycle. A `start` raised while `busy` is 1 is ignored.
- R9: At most one of `xl_req` and `mem_req` is high at a time. Each request, and its address, stays stable until its response-valid is seen.
- R10: After reset, `busy`, `done`, `xl_req` and `mem_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fetch (sampled while idle) |
| pc | input | AW | Program counter for the fetch |
| half_en | input | 1 | Compressed encodings allowed |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | Result valid this cycle |
| res_tag | output | 2 | 00 base word, 01 compressed, 10 error |
| res_insn | output | 32 | Instruction bits |
| res_exc | output | EW | Exception code for the error tag |
| res_addr | output | AW | Faulting virtual address for the error tag |
| xl_req | output | 1 | Translation request |
| xl_vaddr | output | AW | Virtual address to translate |
| xl_rsp_valid | input | 1 | Translation response valid |
| xl_rsp_fault | input | 1 | Translation failed |
| xl_rsp_exc | input | EW | Translator's exception code |
| xl_rsp_paddr | input | AW | Translated physical address |
| mem_req | output | 1 | Halfword read request |
| mem_addr | output | AW | Physical halfword address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_err | input | 1 | Read failed |
| mem_rsp_data | input | 16 | Halfword read data |

## Verification
The embedded properties watch the handshakes on every cycle. They check that requests are held with stable addresses, that the two request types never overlap, that every read follows a translation, and that `done` is a single pulse. They also check that a misaligned start finishes at once, and that the two success tags agree with the low bits of the instruction they carry.

Other behaviour can only be shown by the bench's scenarios, because it depends on what the stubs return. This covers the pass-through of translator codes, the choice between PC and PC+2 as the faulting address, and the exact packing of the two halves. It also covers address wrap at the top of memory and the absence of a second access after a compressed halfword. The bench sweeps PC alignment, the compressed-enable input, all four low-bit patterns, every fault position and three response latencies.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

    localparam int unsigned HALF_W = 16;
    localparam int unsigned WORD_W = 32;

    localparam int unsigned EXC_MISALIGNED   = 0;
    localparam int unsigned EXC_ACCESS_FAULT = 1;

    typedef enum logic [1:0] {
        TAG_BASE = 2'b00,
        TAG_HALF = 2'b01,
        TAG_ERR  = 2'b10
    } fetch_tag_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XLATE_LO,
        ST_READ_LO,
        ST_XLATE_HI,
        ST_READ_HI,
        ST_DONE
    } fetch_state_e;

endpackage

// File: rtl/ifetch_align_chk.sv
module ifetch_align_chk #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] pc_i,
    input  logic          half_en_i,
    output logic          misaligned_o
);
    // Byte-odd addresses never fetch; halfword-odd ones only when compressed is on.
    assign misaligned_o = pc_i[0] | (pc_i[1] & ~half_en_i);
endmodule

// File: rtl/ifetch_half_kind.sv
module ifetch_half_kind
    import ifetch_pkg::*;
(
    input  logic [HALF_W-1:0] hw_i,
    output logic              needs_upper_o
);
    // Both low bits set marks the first half of a 32-bit encoding.
    assign needs_upper_o = &hw_i[1:0];
endmodule

// File: rtl/ifetch_seq.sv
module ifetch_seq
    import ifetch_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         misaligned_i,
    input  logic         xl_valid_i,
    input  logic         xl_fault_i,
    input  logic         mem_valid_i,
    input  logic         mem_err_i,
    input  logic         needs_upper_i,
    output fetch_state_e state_o
);
    fetch_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (start_i) state_d = misaligned_i ? ST_DONE : ST_XLATE_LO;
            ST_XLATE_LO:
                if (xl_valid_i) state_d = xl_fault_i ? ST_DONE : ST_READ_LO;
            ST_READ_LO:
                if (mem_valid_i)
                    state_d = (mem_err_i || !needs_upper_i) ? ST_DONE : ST_XLATE_HI;
            ST_XLATE_HI:
                if (xl_valid_i) state_d = xl_fault_i ? ST_DONE : ST_READ_HI;
            ST_READ_HI:
                if (mem_valid_i) state_d = ST_DONE;
            ST_DONE:
                state_d = ST_IDLE;
            default:
                state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
    import ifetch_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned EW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] pc,
    input  logic          half_en,
    output logic          busy,
    output logic          done,
    output logic [1:0]    res_tag,
    output logic [31:0]   res_insn,
    output logic [EW-1:0] res_exc,
    output logic [AW-1:0] res_addr,
    output logic          xl_req,
    output logic [AW-1:0] xl_vaddr,
    input  logic          xl_rsp_valid,
    input  logic          xl_rsp_fault,
    input  logic [EW-1:0] xl_rsp_exc,
    input  logic [AW-1:0] xl_rsp_paddr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rsp_valid,
    input  logic          mem_rsp_err,
    input  logic [15:0]   mem_rsp_data
);
    localparam logic [AW-1:0]  HALF_STEP = AW'(2);
    localparam logic [EW-1:0]  CODE_MIS  = EW'(EXC_MISALIGNED);
    localparam logic [EW-1:0]  CODE_ACC  = EW'(EXC_ACCESS_FAULT);

    fetch_state_e      state;
    logic              misaligned;
    logic              needs_upper;
    logic [AW-1:0]     pc_q;
    logic [AW-1:0]     pc_hi;
    logic [AW-1:0]     paddr_q;
    logic [HALF_W-1:0] lo_q;
    fetch_tag_e        tag_q;
    logic [WORD_W-1:0] insn_q;
    logic [EW-1:0]     exc_q;
    logic [AW-1:0]     addr_q;

    ifetch_align_chk #(.AW(AW)) u_align (
        .pc_i         (pc),
        .half_en_i    (half_en),
        .misaligned_o (misaligned)
    );

    ifetch_half_kind u_kind (
        .hw_i          (mem_rsp_data),
        .needs_upper_o (needs_upper)
    );

    ifetch_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .misaligned_i  (misaligned),
        .xl_valid_i    (xl_rsp_valid),
        .xl_fault_i    (xl_rsp_fault),
        .mem_valid_i   (mem_rsp_valid),
        .mem_err_i     (mem_rsp_err),
        .needs_upper_i (needs_upper),
        .state_o       (state)
    );

    assign pc_hi = pc_q + HALF_STEP;

    // Datapath: capture addresses, the low half and the result record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            paddr_q <= '0;
            lo_q    <= '0;
            tag_q   <= TAG_BASE;
            insn_q  <= '0;
            exc_q   <= '0;
            addr_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        pc_q <= pc;
                        if (misaligned) begin
                            tag_q  <= TAG_ERR;
                            insn_q <= '0;
                            exc_q  <= CODE_MIS;
                            addr_q <= pc;
                        end
                    end
                end
                ST_XLATE_LO: begin
                    if (xl_rsp_valid) begin
                        if (xl_rsp_fault) begin
                            tag_q  <= TAG_ERR;
                            insn_q <= '0;
                            exc_q  <= xl_rsp_exc;
                            addr_q <= pc_q;
                        end else begin
                            paddr_q <= xl_rsp_paddr;
                        end
                    end
                end
                ST_READ_LO: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            tag_q  <= TAG_ERR;
                            insn_q <= '0;
                            exc_q  <= CODE_ACC;
                            addr_q <= pc_q;
                        end else begin
                            lo_q <= mem_rsp_data;
                            if (!needs_upper) begin
                                tag_q  <= TAG_HALF;
                                insn_q <= {{(WORD_W-HALF_W){1'b0}}, mem_rsp_data};
                                exc_q  <= '0;
                                addr_q <= '0;
                            end
                        end
                    end
                end
                ST_XLATE_HI: begin
                    if (xl_rsp_valid) begin
                        if (xl_rsp_fault) begin
                            tag_q  <= TAG_ERR;
                            insn_q <= '0;
                            exc_q  <= xl_rsp_exc;
                            addr_q <= pc_hi;
                        end else begin
                            paddr_q <= xl_rsp_paddr;
                        end
                    end
                end
                ST_READ_HI: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            tag_q  <= TAG_ERR;
                            insn_q <= '0;
                            exc_q  <= CODE_ACC;
                            addr_q <= pc_hi;
                        end else begin
                            tag_q  <= TAG_BASE;
                            insn_q <= {mem_rsp_data, lo_q};
                            exc_q  <= '0;
                            addr_q <= '0;
                        end
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        xl_req   = (state == ST_XLATE_LO) || (state == ST_XLATE_HI);
        xl_vaddr = (state == ST_XLATE_HI) ? pc_hi : pc_q;
        mem_req  = (state == ST_READ_LO) || (state == ST_READ_HI);
        mem_addr = paddr_q;
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
        res_tag  = tag_q;
        res_insn = insn_q;
        res_exc  = exc_q;
        res_addr = addr_q;
    end

    // R1: a misaligned start completes at once with the misaligned code
    a_r1_misaligned_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && misaligned) |=> (done && res_tag == TAG_ERR && res_exc == CODE_MIS));

    // R3: a read only begins straight after a translation
    a_r3_read_after_xlate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(xl_req));

    // R4: compressed results carry a zero upper half and non-11 low bits
    a_r4_half_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_tag == TAG_HALF) |-> (res_insn[31:16] == 16'h0 && res_insn[1:0] != 2'b11));

    // R5: a full word always has 11 in its low bits
    a_r5_word_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_tag == TAG_BASE) |-> (res_insn[1:0] == 2'b11));

    // R8: done is a single-cycle pulse and the tag is one of three codes
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    a_r8_tag_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_tag != 2'b11));

    // R9: requests are exclusive and held with stable addresses
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(xl_req && mem_req));
    a_r9_xl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && !xl_rsp_valid) |=> (xl_req && $stable(xl_vaddr)));
    a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: tb/ifetch_unit_test.sv
module ifetch_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int EW = 5;
    localparam logic [AW-1:0] OFS = 32'h8000_4000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] pc = '0;
    logic          half_en = 1'b0;
    logic          busy, done;
    logic [1:0]    res_tag;
    logic [31:0]   res_insn;
    logic [EW-1:0] res_exc;
    logic [AW-1:0] res_addr;
    logic          xl_req;
    logic [AW-1:0] xl_vaddr;
    logic          xl_rsp_valid, xl_rsp_fault;
    logic [EW-1:0] xl_rsp_exc;
    logic [AW-1:0] xl_rsp_paddr;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rsp_valid, mem_rsp_err;
    logic [15:0]   mem_rsp_data;

    ifetch_unit #(.AW(AW), .EW(EW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pc(pc), .half_en(half_en),
        .busy(busy), .done(done), .res_tag(res_tag), .res_insn(res_insn),
        .res_exc(res_exc), .res_addr(res_addr),
        .xl_req(xl_req), .xl_vaddr(xl_vaddr), .xl_rsp_valid(xl_rsp_valid),
        .xl_rsp_fault(xl_rsp_fault), .xl_rsp_exc(xl_rsp_exc), .xl_rsp_paddr(xl_rsp_paddr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Stub configuration, set by the stimulus before each fetch
    int            lat = 0;
    logic          xf_lo = 0, xf_hi = 0, mf_lo = 0, mf_hi = 0;
    logic [EW-1:0] xcode = '0;
    logic [15:0]   lo_val = '0, hi_val = '0;
    logic [AW-1:0] cur_pc = '0;
    logic          clr = 1'b0;

    int            xl_wait = 0, xl_n = 0, mem_wait = 0, mem_n = 0;
    logic [AW-1:0] xl_log [0:1];
    logic [AW-1:0] mem_log [0:1];

    always_comb begin
        xl_rsp_valid  = xl_req && (xl_wait >= lat);
        xl_rsp_fault  = (xl_vaddr == cur_pc) ? xf_lo : xf_hi;
        xl_rsp_exc    = xcode;
        xl_rsp_paddr  = xl_vaddr ^ OFS;
        mem_rsp_valid = mem_req && (mem_wait >= lat);
        mem_rsp_err   = (mem_addr == (cur_pc ^ OFS)) ? mf_lo : mf_hi;
        mem_rsp_data  = (mem_addr == (cur_pc ^ OFS)) ? lo_val : hi_val;
    end

    always @(posedge clk) begin
        if (clr) begin
            xl_n <= 0; mem_n <= 0; xl_wait <= 0; mem_wait <= 0;
        end else begin
            if (xl_req) begin
                if (xl_rsp_valid) begin
                    if (xl_n < 2) xl_log[xl_n] <= xl_vaddr;
                    xl_n <= xl_n + 1;
                    xl_wait <= 0;
                end else xl_wait <= xl_wait + 1;
            end
            if (mem_req) begin
                if (mem_rsp_valid) begin
                    if (mem_n < 2) mem_log[mem_n] <= mem_addr;
                    mem_n <= mem_n + 1;
                    mem_wait <= 0;
                end else mem_wait <= mem_wait + 1;
            end
        end
    end

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_fetch(input bit poke);
        bit          misal;
        logic [1:0]  etag;
        logic [31:0] einsn;
        logic [EW-1:0] eexc;
        logic [AW-1:0] eaddr;
        int          exl, emem, cyc;
        logic [AW-1:0] pc_hi;
        string       rq;
        pc_hi = cur_pc + 32'd2;
        misal = cur_pc[0] || (cur_pc[1] && !half_en);
        einsn = '0; eexc = '0; eaddr = '0;
        if (misal) begin
            etag = 2'b10; eexc = 5'd0; eaddr = cur_pc; exl = 0; emem = 0;
            rq = cur_pc[0] ? "R1" : "R2";
        end else if (xf_lo) begin
            etag = 2'b10; eexc = xcode; eaddr = cur_pc; exl = 1; emem = 0; rq = "R6";
        end else if (mf_lo) begin
            etag = 2'b10; eexc = 5'd1; eaddr = cur_pc; exl = 1; emem = 1; rq = "R7";
        end else if (lo_val[1:0] != 2'b11) begin
            etag = 2'b01; einsn = {16'h0, lo_val}; exl = 1; emem = 1; rq = "R4";
        end else if (xf_hi) begin
            etag = 2'b10; eexc = xcode; eaddr = pc_hi; exl = 2; emem = 1; rq = "R6";
        end else if (mf_hi) begin
            etag = 2'b10; eexc = 5'd1; eaddr = pc_hi; exl = 2; emem = 2; rq = "R7";
        end else begin
            etag = 2'b00; einsn = {hi_val, lo_val}; exl = 2; emem = 2; rq = "R5";
        end

        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0; pc = cur_pc; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R8", "busy after start", 64'(busy), 64'd1);
        if (poke) begin
            pc = cur_pc ^ 32'h41; start = 1'b1;
            @(negedge clk); start = 1'b0; pc = cur_pc;
        end
        cyc = 0;
        while (!done && cyc < 100) begin
            @(negedge clk); cyc++;
        end
        chk(done == 1'b1, "R8", "done reached", 64'(done), 64'd1);
        if (misal)
            chk(cyc == 0, rq, "misaligned latency", 64'(cyc), 64'd0);
        chk(res_tag == etag, rq, "tag", 64'(res_tag), 64'(etag));
        if (etag == 2'b10) begin
            chk(res_exc == eexc, rq, "exception code", 64'(res_exc), 64'(eexc));
            chk(res_addr == eaddr, rq, "fault address", 64'(res_addr), 64'(eaddr));
        end else begin
            chk(res_insn == einsn, rq, "instruction", 64'(res_insn), 64'(einsn));
        end
        chk(xl_n == exl, "R3", "translation count", 64'(xl_n), 64'(exl));
        chk(mem_n == emem, "R3", "read count", 64'(mem_n), 64'(emem));
        if (exl >= 1) chk(xl_log[0] == cur_pc, "R3", "first vaddr", 64'(xl_log[0]), 64'(cur_pc));
        if (exl >= 2) chk(xl_log[1] == pc_hi, "R3", "second vaddr", 64'(xl_log[1]), 64'(pc_hi));
        if (emem >= 1) chk(mem_log[0] == (cur_pc ^ OFS), "R3", "first paddr",
                           64'(mem_log[0]), 64'(cur_pc ^ OFS));
        if (emem >= 2) chk(mem_log[1] == (pc_hi ^ OFS), "R3", "second paddr",
                           64'(mem_log[1]), 64'(pc_hi ^ OFS));
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R8", "done single cycle", {62'd0, done, busy}, 64'd0);
    endtask

    initial begin
        logic [AW-1:0] pcs [0:5];
        pcs[0] = 32'h0000_1000; pcs[1] = 32'h0000_1002; pcs[2] = 32'h0000_1001;
        pcs[3] = 32'h0000_1003; pcs[4] = 32'h0FFF_FFFE; pcs[5] = 32'hFFFF_FFFE;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(busy == 0 && done == 0, "R10", "busy/done in reset", {62'd0, busy, done}, 64'd0);
        chk(xl_req == 0 && mem_req == 0, "R10", "requests in reset",
            {62'd0, xl_req, mem_req}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && xl_req == 0 && mem_req == 0, "R10", "idle after reset",
            {60'd0, busy, done, xl_req, mem_req}, 64'd0);

        for (int p = 0; p < 6; p++)
            for (int en = 0; en < 2; en++)
                for (int b = 0; b < 4; b++)
                    for (int f = 0; f < 5; f++)
                        for (int l = 0; l < 3; l++) begin
                            cur_pc  = pcs[p];
                            half_en = en[0];
                            lo_val  = 16'hA5C0 | 16'(b) | 16'(p << 4);
                            hi_val  = 16'h3C5A ^ 16'(f * 37 + l);
                            xf_lo   = (f == 1); mf_lo = (f == 2);
                            xf_hi   = (f == 3); mf_hi = (f == 4);
                            xcode   = 5'(12 + p + f);
                            lat     = l;
                            run_fetch(1'b0);
                        end

        // R8: start during a fetch is ignored
        cur_pc = 32'h0000_0100; half_en = 1'b1; lo_val = 16'h1233; hi_val = 16'hBEEF;
        xf_lo = 0; mf_lo = 0; xf_hi = 0; mf_hi = 0; lat = 2;
        run_fetch(1'b1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R8 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule